// File: doc/BRIEF.md
# Indexed Real-Time-Clock Register Port

This block is the register front end of a real-time clock's small configuration RAM. A host reaches it through two byte-wide ports that share one strobe interface. The `portSel` input plays the part of the least significant address bit. With `portSel` at 0, a write loads a 7-bit pointer. With `portSel` at 1, an access reads or writes the location that the pointer selects. Behind the pointer sit 128 byte locations. The time, alarm and century bytes are kept here as plain storage only; a separate timekeeping block owns the counting.

Four locations act as control registers and have side effects:

| Index | Role |
|-------|------|
| 0x0A | Rate and update status |
| 0x0B | Mode and interrupt enables |
| 0x0C | Event flags |
| 0x0D | Validity status |

The flag register collects three hardware events: periodic, alarm and update-ended. It also carries a summary bit that drives the single `irqOut` line. Reading the flag register acknowledges and clears it. Setting the halt bit in the mode register strips the update-interrupt enable and clears the update-in-progress status. Enabling an interrupt whose flag is already pending raises the line at once.

A data access at the legacy century index 0x37 is steered to the standard century byte at 0x32. The pointer is moved to 0x32 as well.

Top module: `rtc_port`

## Requirements
- R1: A write with `portSel`=0 stores `wrData[6:0]` as the pointer, and bit 7 is dropped. A read with `portSel`=0 returns 0xFF.
- R2: Any index other than 0x0A to 0x0D and 0x37 behaves as plain byte storage that reads back what was last written. This includes the time bytes 0x00 to 0x09 and the alarm bytes 0x01, 0x03 and 0x05.
- R3: Writes to the flag register (0x0C) and the status register (0x0D) have no effect. The status register reads 0x80.
- R4: A data read of the flag register returns its present value. Afterwards the register becomes 0x00 and `irqOut` goes low, unless an event arrives in that cycle (R9).
- R5: Bit 7 of register 0x0A is the update-in-progress flag and is read-only. A write replaces bits 6:0 and keeps bit 7. Bit 7 is set by `evtUpdStart` and cleared by `evtUpdDone`.
- R6: A write to 0x0B with bit 7 (halt) high stores bit 4 (update-interrupt enable) as 0 and clears bit 7 of 0x0A in the same cycle.
- R7: On any write to 0x0B, the block checks the new enables in bits 6:4 against the pending flags in bits 6:4 of 0x0C. If any pair matches, bit 7 of 0x0C is set and `irqOut` rises one cycle later. If none matches, bit 7 is cleared and `irqOut` falls.
- R8: `evtPeriodic`, `evtAlarm` and `evtUpdDone` set bits 6, 5 and 4 of 0x0C respectively, whatever the enables are. When the matching enable in 0x0B is high, the event also sets bit 7 and raises `irqOut`.
- R9: An event arriving in the same cycle as a read of 0x0C survives the clear: its flag, and bit 7 if enabled, are set after that cycle.
- R10: A data access at index 0x37 reads or writes location 0x32 and moves the pointer to 0x32.
- R11: After reset, the registers hold 0x0A=0x26, 0x0B=0x02, 0x0C=0x00, 0x0D=0x80, the pointer holds 0 and `irqOut` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| portSel | input | 1 | 0 selects the pointer port, 1 selects the data port |
| wrEn | input | 1 | Write strobe; wins over `rdEn` |
| rdEn | input | 1 | Read strobe; side effects apply at the clock edge |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the currently selected port and index (combinational) |
| evtPeriodic | input | 1 | Periodic tick from the timekeeper |
| evtAlarm | input | 1 | Alarm match from the timekeeper |
| evtUpdStart | input | 1 | Timekeeper begins an update |
| evtUpdDone | input | 1 | Timekeeper finished an update |
| irqOut | output | 1 | Interrupt line, equal to flag bit 7 |

## Verification
Some properties are checked on every cycle, next to the registers they guard:
- the halt bit never coexists with the update-interrupt enable;
- the status register never changes on a write;
- a plain write to 0x0A preserves the busy bit;
- an event always leaves its flag set on the next cycle, even across an acknowledging read;
- a mode write with no matching pending flag leaves the line low.

Other behaviour shows only in the directed scenarios:
- the value returned by a flag read before it clears;
- an interrupt raised the moment an enable meets an old flag;
- pointer masking;
- century redirection.

// File: rtl/rtc_port_pkg.sv
package rtc_port_pkg;
  localparam int IDX_W  = 7;
  localparam int DATA_W = 8;

  localparam logic [IDX_W-1:0] IDX_RATE   = 7'h0A;
  localparam logic [IDX_W-1:0] IDX_MODE   = 7'h0B;
  localparam logic [IDX_W-1:0] IDX_FLAGS  = 7'h0C;
  localparam logic [IDX_W-1:0] IDX_STAT   = 7'h0D;
  localparam logic [IDX_W-1:0] IDX_CENT   = 7'h32;
  localparam logic [IDX_W-1:0] IDX_CENT_L = 7'h37;

  localparam logic [DATA_W-1:0] RST_RATE  = 8'h26;
  localparam logic [DATA_W-1:0] RST_MODE  = 8'h02;
  localparam logic [DATA_W-1:0] RST_FLAGS = 8'h00;
  localparam logic [DATA_W-1:0] RST_STAT  = 8'h80;
  localparam logic [DATA_W-1:0] IDX_READ  = 8'hFF;

  // bit positions shared by mode (enables) and flag registers
  localparam int BIT_BUSY = 7;   // rate register busy flag
  localparam int BIT_HALT = 7;   // mode register halt
  localparam int BIT_IRQ  = 7;   // flag register summary
  localparam int BIT_PER  = 6;
  localparam int BIT_ALM  = 5;
  localparam int BIT_UPD  = 4;
  localparam logic [DATA_W-1:0] EVT_MASK = 8'h70;

  typedef struct packed {
    logic idxWr;
    logic dataWr;
    logic dataRd;
    logic selRate;
    logic selMode;
    logic selFlags;
    logic selStat;
    logic selPlain;
    logic redirect;
  } strobe_t;
endpackage

// File: rtl/rtc_port_ctrl.sv
module rtc_port_ctrl
  import rtc_port_pkg::*;
#(
  parameter int IW = IDX_W
) (
  input  logic          portSel,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic [IW-1:0] curIdx,
  output strobe_t       strb,
  output logic [IW-1:0] effIdx
);
  logic isAlt;

  always_comb begin
    isAlt  = (curIdx == IW'(IDX_CENT_L));
    effIdx = isAlt ? IW'(IDX_CENT) : curIdx;

    strb          = '0;
    strb.idxWr    = wrEn && !portSel;
    strb.dataWr   = wrEn && portSel;
    strb.dataRd   = rdEn && !wrEn && portSel;
    strb.selRate  = (effIdx == IW'(IDX_RATE));
    strb.selMode  = (effIdx == IW'(IDX_MODE));
    strb.selFlags = (effIdx == IW'(IDX_FLAGS));
    strb.selStat  = (effIdx == IW'(IDX_STAT));
    strb.selPlain = !(strb.selRate || strb.selMode || strb.selFlags || strb.selStat);
    strb.redirect = isAlt && (strb.dataWr || strb.dataRd);
  end
endmodule

// File: rtl/rtc_port_dp.sv
module rtc_port_dp
  import rtc_port_pkg::*;
#(
  parameter int IW = IDX_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       strb,
  input  logic [IW-1:0] effIdx,
  input  logic          portSel,
  input  logic [DW-1:0] wrData,
  input  logic          evtPeriodic,
  input  logic          evtAlarm,
  input  logic          evtUpdStart,
  input  logic          evtUpdDone,
  output logic [IW-1:0] curIdx,
  output logic [DW-1:0] rdData,
  output logic          irqOut
);
  localparam int DEPTH = 1 << IW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] regRate, regMode, regFlags, regStat;
  logic [DW-1:0] modeNext, flagsNext, flagBase, evtBits;
  logic          busyNext, wrMode, wrRate, rdFlags, anyEvt;

  assign wrMode  = strb.dataWr && strb.selMode;
  assign wrRate  = strb.dataWr && strb.selRate;
  assign rdFlags = strb.dataRd && strb.selFlags;
  assign anyEvt  = evtPeriodic || evtAlarm || evtUpdDone;

  always_comb begin
    evtBits          = '0;
    evtBits[BIT_PER] = evtPeriodic;
    evtBits[BIT_ALM] = evtAlarm;
    evtBits[BIT_UPD] = evtUpdDone;

    modeNext = regMode;
    if (wrMode) begin
      modeNext = wrData;
      if (wrData[BIT_HALT]) modeNext[BIT_UPD] = 1'b0;
    end

    flagBase  = rdFlags ? '0 : regFlags;
    flagsNext = (flagBase | evtBits) & EVT_MASK;
    if (wrMode)
      flagsNext[BIT_IRQ] = |(modeNext & flagsNext & EVT_MASK);
    else
      flagsNext[BIT_IRQ] = flagBase[BIT_IRQ] | (|(evtBits & modeNext & EVT_MASK));

    busyNext = regRate[BIT_BUSY];
    if (wrMode && wrData[BIT_HALT]) busyNext = 1'b0;
    else if (evtUpdDone)            busyNext = 1'b0;
    else if (evtUpdStart)           busyNext = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curIdx   <= '0;
      regRate  <= RST_RATE;
      regMode  <= RST_MODE;
      regFlags <= RST_FLAGS;
      regStat  <= RST_STAT;
    end else begin
      if (strb.idxWr)         curIdx <= wrData[IW-1:0];
      else if (strb.redirect) curIdx <= effIdx;
      regRate[DW-2:0] <= wrRate ? wrData[DW-2:0] : regRate[DW-2:0];
      regRate[BIT_BUSY] <= busyNext;
      regMode  <= modeNext;
      regFlags <= flagsNext;
      regStat  <= RST_STAT;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (strb.dataWr && strb.selPlain) begin
      mem[effIdx] <= wrData;
    end
  end

  always_comb begin
    if (!portSel)           rdData = IDX_READ;
    else if (strb.selRate)  rdData = regRate;
    else if (strb.selMode)  rdData = regMode;
    else if (strb.selFlags) rdData = regFlags;
    else if (strb.selStat)  rdData = regStat;
    else                    rdData = mem[effIdx];
  end

  assign irqOut = regFlags[BIT_IRQ];

  AST_HALT_NO_UIE: assert property (@(posedge clk) disable iff (!rstN)
    regMode[BIT_HALT] |-> !regMode[BIT_UPD]); // R6
  AST_STAT_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    (strb.dataWr && strb.selStat) |=> (regStat == RST_STAT)); // R3
  AST_BUSY_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (wrRate && !evtUpdStart && !evtUpdDone) |=> (regRate[BIT_BUSY] == $past(regRate[BIT_BUSY]))); // R5
  AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    (rdFlags && !anyEvt) |=> (regFlags == '0 && !irqOut)); // R4
  AST_PER_STICKS: assert property (@(posedge clk) disable iff (!rstN)
    evtPeriodic |=> regFlags[BIT_PER]); // R9
  AST_ALM_STICKS: assert property (@(posedge clk) disable iff (!rstN)
    evtAlarm |=> regFlags[BIT_ALM]); // R8
  AST_MODE_NO_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (wrMode && !anyEvt && ((wrData & regFlags & EVT_MASK) == '0)) |=> !irqOut); // R7
endmodule

// File: rtl/rtc_port.sv
module rtc_port
  import rtc_port_pkg::*;
#(
  parameter int IW = IDX_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          portSel,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData,
  input  logic          evtPeriodic,
  input  logic          evtAlarm,
  input  logic          evtUpdStart,
  input  logic          evtUpdDone,
  output logic          irqOut
);
  strobe_t       strb;
  logic [IW-1:0] curIdx, effIdx;

  rtc_port_ctrl #(.IW(IW)) uCtrl (
    .portSel(portSel), .wrEn(wrEn), .rdEn(rdEn), .curIdx(curIdx),
    .strb(strb), .effIdx(effIdx)
  );

  rtc_port_dp #(.IW(IW), .DW(DW)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .effIdx(effIdx), .portSel(portSel),
    .wrData(wrData), .evtPeriodic(evtPeriodic), .evtAlarm(evtAlarm),
    .evtUpdStart(evtUpdStart), .evtUpdDone(evtUpdDone),
    .curIdx(curIdx), .rdData(rdData), .irqOut(irqOut)
  );
endmodule

// File: tb/rtc_port_test.sv
module rtc_port_test;
  logic clk = 1'b0, rstN = 1'b0;
  logic portSel = 1'b0, wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic evtPeriodic = 1'b0, evtAlarm = 1'b0, evtUpdStart = 1'b0, evtUpdDone = 1'b0;
  logic irqOut;
  int checks = 0, fails = 0;
  logic [7:0] got;

  always #4 clk = ~clk;

  rtc_port uut (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic sel, input logic [7:0] v);
    @(negedge clk); portSel = sel; wrData = v; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic busRead(input logic sel, output logic [7:0] v);
    @(negedge clk); portSel = sel; rdEn = 1'b1;
    #1 v = rdData;
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic regWrite(input logic [7:0] idx, input logic [7:0] v);
    busWrite(1'b0, idx); busWrite(1'b1, v);
  endtask

  task automatic regRead(input logic [7:0] idx, output logic [7:0] v);
    busWrite(1'b0, idx); busRead(1'b1, v);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: evtPeriodic = 1'b1;
      1: evtAlarm = 1'b1;
      2: evtUpdStart = 1'b1;
      default: evtUpdDone = 1'b1;
    endcase
    @(negedge clk);
    evtPeriodic = 1'b0; evtAlarm = 1'b0; evtUpdStart = 1'b0; evtUpdDone = 1'b0;
  endtask

  task automatic tReset;
    check("R11 irq", {7'd0, irqOut}, 8'h00);
    busRead(1'b1, got); check("R11 index 0 storage", got, 8'h00);
    regRead(8'h0A, got); check("R11 rate", got, 8'h26);
    regRead(8'h0B, got); check("R11 mode", got, 8'h02);
    regRead(8'h0D, got); check("R11 status", got, 8'h80);
    regRead(8'h0C, got); check("R11 flags", got, 8'h00);
    busRead(1'b0, got); check("R1 pointer port read", got, 8'hFF);
  endtask

  task automatic tPointer;
    busWrite(1'b0, 8'hC5); busWrite(1'b1, 8'h5A);
    regRead(8'h45, got); check("R1 pointer masked", got, 8'h5A);
  endtask

  task automatic tPlain;
    regWrite(8'h00, 8'h59); regWrite(8'h01, 8'h30); regWrite(8'h7F, 8'hA5); regWrite(8'h20, 8'h3C);
    regRead(8'h00, got); check("R2 time byte", got, 8'h59);
    regRead(8'h01, got); check("R2 alarm byte", got, 8'h30);
    regRead(8'h7F, got); check("R2 top byte", got, 8'hA5);
    regRead(8'h20, got); check("R2 mid byte", got, 8'h3C);
  endtask

  task automatic tReadOnly;
    regWrite(8'h0C, 8'hFF); regWrite(8'h0D, 8'h00);
    check("R3 irq after flag write", {7'd0, irqOut}, 8'h00);
    regRead(8'h0D, got); check("R3 status unchanged", got, 8'h80);
    regRead(8'h0C, got); check("R3 flags unchanged", got, 8'h00);
  endtask

  task automatic tBusy;
    pulse(2);
    regRead(8'h0A, got); check("R5 busy set", got, 8'hA6);
    regWrite(8'h0A, 8'h11);
    regRead(8'h0A, got); check("R5 busy kept on write", got, 8'h91);
    pulse(3);
    regRead(8'h0A, got); check("R5 busy cleared", got, 8'h11);
    regRead(8'h0C, got); check("R8 update flag", got, 8'h10);
    check("R8 no irq when disabled", {7'd0, irqOut}, 8'h00);
  endtask

  task automatic tHalt;
    pulse(2);
    regWrite(8'h0B, 8'h92);
    regRead(8'h0B, got); check("R6 uie stripped", got, 8'h82);
    regRead(8'h0A, got); check("R6 busy cleared", got, 8'h11);
  endtask

  task automatic tEvents;
    regWrite(8'h0B, 8'h00);
    pulse(0);
    check("R8 periodic no irq", {7'd0, irqOut}, 8'h00);
    regRead(8'h0C, got); check("R8 periodic flag", got, 8'h40);
    regWrite(8'h0B, 8'h40);
    pulse(0);
    check("R8 periodic irq", {7'd0, irqOut}, 8'h01);
    regRead(8'h0C, got); check("R4 read value", got, 8'hC0);
    check("R4 irq dropped", {7'd0, irqOut}, 8'h00);
    busRead(1'b1, got); check("R4 cleared", got, 8'h00);
  endtask

  task automatic tPending;
    regWrite(8'h0B, 8'h00);
    pulse(1);
    check("R7 alarm no irq yet", {7'd0, irqOut}, 8'h00);
    regWrite(8'h0B, 8'h20);
    check("R7 enable raises irq", {7'd0, irqOut}, 8'h01);
    regWrite(8'h0B, 8'h00);
    check("R7 disable drops irq", {7'd0, irqOut}, 8'h00);
    regRead(8'h0C, got); check("R7 flag kept, summary clear", got, 8'h20);
  endtask

  task automatic tRace;
    regWrite(8'h0B, 8'h20);
    busWrite(1'b0, 8'h0C);
    @(negedge clk); portSel = 1'b1; rdEn = 1'b1; evtAlarm = 1'b1;
    #1 got = rdData;
    @(negedge clk); rdEn = 1'b0; evtAlarm = 1'b0;
    check("R9 read value before event", got, 8'h00);
    check("R9 irq survives", {7'd0, irqOut}, 8'h01);
    busRead(1'b1, got); check("R9 flag survives", got, 8'hA0);
    regWrite(8'h0B, 8'h00);
  endtask

  task automatic tCentury;
    regWrite(8'h32, 8'h20);
    regRead(8'h37, got); check("R10 legacy read", got, 8'h20);
    busWrite(1'b1, 8'h55);
    regRead(8'h32, got); check("R10 pointer moved", got, 8'h55);
    regWrite(8'h37, 8'h77);
    regRead(8'h32, got); check("R10 legacy write", got, 8'h77);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset; tPointer; tPlain; tReadOnly; tBusy; tHalt;
    tEvents; tPending; tRace; tCentury;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule